// File: doc/BRIEF.md
# Per-Link Sequence Integrity Checker

This block checks each incoming frame descriptor against the sequence history of its virtual link and decides whether the frame passes or is dropped. Each descriptor carries a link identifier and an 8-bit sequence number. The block keeps the last accepted sequence number for every link in a small internal memory. Each redundant receive channel has its own instance, and the instances run side by side with no shared state.

A frame passes when its number is one or two past the stored value for its link, so one lost frame in between causes no error. Sequence value 0 means the transmitter has restarted. It is always accepted and sets the stored value back to 0. Counting skips 0, so the value after 255 is 1. A rejected frame leaves the stored value unchanged. The drop is reported by a one-cycle error pulse together with the link identifier.

Top module: `seq_integrity_chk`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid`, `out_pass`, `out_drop` and `err_pulse` are all 0.
- R2: A descriptor sampled with `in_valid`=1 at a rising edge gives exactly one decision, with `out_valid`=1 during the following clock cycle. With no descriptor there is no decision.
- R3: The first frame on a link after reset is accepted whatever its sequence number, and its number becomes the stored value for that link.
- R4: A frame whose sequence number equals succ(stored) is accepted and becomes the stored value. succ(x) is x+1 for x<255, and succ(255)=1.
- R5: A frame whose sequence number equals succ(succ(stored)) is accepted and becomes the stored value, so one missing frame is tolerated.
- R6: Any other non-zero number is dropped: `out_drop`=1, `err_pulse`=1, and `err_link` carries the link ID. Repeats, jumps of three or more and backward steps all count. The stored value does not change.
- R7: Wrap-around skips 0. After 254, the numbers 255 and 1 are accepted. After 255, the numbers 1 and 2 are accepted. After a stored value of 255, the number 0 counts as a restart (R8), not as a successor.
- R8: Sequence number 0 is always accepted and sets the stored value to 0. After that, 1 and 2 are accepted.
- R9: Each link's history is independent. Frames on one link never change the verdict for another link.
- R10: Back-to-back descriptors on the same link in consecutive cycles are judged against the value written by the frame just before.
- R11: When `out_valid`=1, exactly one of `out_pass` and `out_drop` is 1. `err_pulse` equals `out_drop`. When `out_valid`=0, all three are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Descriptor present this cycle |
| in_link | input | LINK_W (7) | Virtual link identifier |
| in_seq | input | SEQ_W (8) | Frame sequence number |
| out_valid | output | 1 | A decision is presented this cycle |
| out_pass | output | 1 | The frame is accepted |
| out_drop | output | 1 | The frame is rejected |
| err_pulse | output | 1 | One-cycle error indication for a rejected frame |
| err_link | output | LINK_W (7) | Link of the rejected frame (0 when there is no error) |

## Verification
The assertions check four behaviours on every cycle:
- Each descriptor produces exactly one decision in the next cycle.
- A decision is exclusive: pass or drop, never both.
- A restart value of 0 is never dropped, and a repeated number is never accepted.
- The read-modify-write bypass returns the value that was just written.

Only the bench scenarios can show the arithmetic of the acceptance window: the +1 and +2 steps, both wrap cases around 255, the fact that a dropped frame leaves the stored history intact, and the independence of links. The bench drives these scenarios and compares every cycle against a behavioural model.

// File: rtl/seqchk_pkg.sv
package seqchk_pkg;
  typedef enum logic [2:0] {
    VERD_DROP    = 3'd0,
    VERD_FIRST   = 3'd1,
    VERD_RESTART = 3'd2,
    VERD_NEXT    = 3'd3,
    VERD_SKIP    = 3'd4
  } verdict_e;
endpackage

// File: rtl/seqchk_link_mem.sv
module seqchk_link_mem #(
  parameter int LINKS  = 128,
  parameter int SEQ_W  = 8,
  parameter int LINK_W = $clog2(LINKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [LINK_W-1:0] rd_link,
  input  logic              wr_en,
  input  logic [LINK_W-1:0] wr_link,
  input  logic [SEQ_W-1:0]  wr_seq,
  output logic [SEQ_W-1:0]  rd_prev,
  output logic              rd_seen
);
  logic [SEQ_W-1:0] prev_q [LINKS];
  logic [LINKS-1:0] seen_q, seen_d;
  logic [SEQ_W-1:0] rd_prev_q, rd_prev_d;
  logic             rd_seen_q, rd_seen_d;
  logic             fwd;

  // The link being written this cycle is the one being read: take the new value.
  assign fwd = wr_en && (wr_link == rd_link);

  always_comb begin
    seen_d = seen_q;
    if (wr_en) seen_d[wr_link] = 1'b1;
    rd_prev_d = fwd ? wr_seq : prev_q[rd_link];
    rd_seen_d = fwd ? 1'b1   : seen_q[rd_link];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q    <= '0;
      rd_seen_q <= 1'b0;
    end else begin
      seen_q <= seen_d;
      if (rd_en) rd_seen_q <= rd_seen_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) prev_q[wr_link] <= wr_seq;
    if (rd_en) rd_prev_q <= rd_prev_d;
  end

  assign rd_prev = rd_prev_q;
  assign rd_seen = rd_seen_q;

  // R10
  bypass_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && wr_en && wr_link == rd_link) |=> (rd_seen && rd_prev == $past(wr_seq)));
endmodule

// File: rtl/seqchk_decide.sv
module seqchk_decide
  import seqchk_pkg::*;
#(
  parameter int SEQ_W = 8
) (
  input  logic [SEQ_W-1:0] seq,
  input  logic [SEQ_W-1:0] prev,
  input  logic             seen,
  output verdict_e         verdict,
  output logic             accept
);
  localparam logic [SEQ_W-1:0] SEQ_MAX = {SEQ_W{1'b1}};
  localparam logic [SEQ_W-1:0] SEQ_ONE = {{(SEQ_W-1){1'b0}}, 1'b1};

  logic [SEQ_W-1:0] exp_next, exp_skip;

  // Successor skips the reserved value 0.
  assign exp_next = (prev     == SEQ_MAX) ? SEQ_ONE : prev + SEQ_ONE;
  assign exp_skip = (exp_next == SEQ_MAX) ? SEQ_ONE : exp_next + SEQ_ONE;

  always_comb begin
    if (seq == '0)             verdict = VERD_RESTART;
    else if (!seen)            verdict = VERD_FIRST;
    else if (seq == exp_next)  verdict = VERD_NEXT;
    else if (seq == exp_skip)  verdict = VERD_SKIP;
    else                       verdict = VERD_DROP;
  end

  assign accept = (verdict != VERD_DROP);
endmodule

// File: rtl/seq_integrity_chk.sv
module seq_integrity_chk #(
  parameter int LINKS  = 128,
  parameter int SEQ_W  = 8,
  parameter int LINK_W = $clog2(LINKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [LINK_W-1:0] in_link,
  input  logic [SEQ_W-1:0]  in_seq,
  output logic              out_valid,
  output logic              out_pass,
  output logic              out_drop,
  output logic              err_pulse,
  output logic [LINK_W-1:0] err_link
);
  import seqchk_pkg::*;

  logic              v1_q, v1_d;
  logic [LINK_W-1:0] link1_q;
  logic [SEQ_W-1:0]  seq1_q;
  logic [SEQ_W-1:0]  rd_prev;
  logic              rd_seen;
  logic              accept;
  logic              wr_en;
  verdict_e          verdict;

  assign v1_d = in_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v1_q <= 1'b0;
    else        v1_q <= v1_d;
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      link1_q <= in_link;
      seq1_q  <= in_seq;
    end
  end

  assign wr_en = v1_q && accept;

  seqchk_link_mem #(.LINKS(LINKS), .SEQ_W(SEQ_W), .LINK_W(LINK_W)) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (in_valid),
    .rd_link (in_link),
    .wr_en   (wr_en),
    .wr_link (link1_q),
    .wr_seq  (seq1_q),
    .rd_prev (rd_prev),
    .rd_seen (rd_seen)
  );

  seqchk_decide #(.SEQ_W(SEQ_W)) u_decide (
    .seq     (seq1_q),
    .prev    (rd_prev),
    .seen    (rd_seen),
    .verdict (verdict),
    .accept  (accept)
  );

  assign out_valid = v1_q;
  assign out_pass  = v1_q && accept;
  assign out_drop  = v1_q && !accept;
  assign err_pulse = out_drop;
  assign err_link  = out_drop ? link1_q : '0;

  // R2
  one_decision_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R2
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R11
  exclusive_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot({out_pass, out_drop}));
  // R8
  restart_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && seq1_q == '0) |-> out_pass);
  // R6
  no_dup_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_pass && rd_seen && seq1_q != '0) |-> (seq1_q != rd_prev));
endmodule

// File: tb/tb_seq_integrity_chk.sv
`timescale 1ns/1ps
module tb_seq_integrity_chk;
  localparam int LINKS  = 128;
  localparam int SEQ_W  = 8;
  localparam int LINK_W = $clog2(LINKS);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic [LINK_W-1:0] in_link = '0;
  logic [SEQ_W-1:0]  in_seq = '0;
  logic              out_valid, out_pass, out_drop, err_pulse;
  logic [LINK_W-1:0] err_link;

  int checks = 0;
  int fails  = 0;
  int ref_prev [LINKS];
  bit ref_seen [LINKS];
  bit exp_v = 0, exp_p = 0;
  int exp_l = 0;
  string exp_tag = "R1";
  bit done = 0;

  always #5 clk = ~clk;

  seq_integrity_chk #(.LINKS(LINKS), .SEQ_W(SEQ_W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_link(in_link),
    .in_seq(in_seq), .out_valid(out_valid), .out_pass(out_pass),
    .out_drop(out_drop), .err_pulse(err_pulse), .err_link(err_link));

  function automatic int succ(int x);
    return (x == 255) ? 1 : x + 1;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare the previous cycle's expectation, then drive a new descriptor.
  task automatic step(bit v, int link, int seq, string tag);
    bit ok;
    @(negedge clk);
    chk({exp_tag, " valid"}, out_valid, exp_v);
    chk({exp_tag, " pass"},  out_pass,  exp_v & exp_p);
    chk({exp_tag, " drop"},  out_drop,  exp_v & !exp_p);
    chk({exp_tag, " err"},   err_pulse, exp_v & !exp_p);
    if (exp_v && !exp_p) chk({exp_tag, " err_link"}, err_link, exp_l);
    ok = 0;
    if (v) begin
      if (seq == 0) ok = 1;
      else if (!ref_seen[link]) ok = 1;
      else if (seq == succ(ref_prev[link]) || seq == succ(succ(ref_prev[link]))) ok = 1;
      if (ok) begin
        ref_prev[link] = seq;
        ref_seen[link] = 1;
      end
    end
    exp_v = v; exp_p = ok; exp_l = link; exp_tag = tag;
    in_valid = v;
    in_link  = LINK_W'(link);
    in_seq   = SEQ_W'(seq);
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < LINKS; i++) begin ref_prev[i] = 0; ref_seen[i] = 0; end
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", out_valid, 0);
    chk("R1 err in reset", err_pulse, 0);
    rst_n = 1'b1;
    step(0, 0, 0, "R1");
    step(0, 0, 0, "R1");
    // R3 first frame, R4, R5, R6 drops leave state intact
    step(1, 5, 10, "R3");
    step(0, 0, 0,  "R3");
    step(1, 5, 11, "R4");
    step(0, 0, 0,  "R4");
    step(1, 5, 13, "R5");
    step(0, 0, 0,  "R5");
    step(1, 5, 13, "R6 duplicate");
    step(0, 0, 0,  "R6");
    step(1, 5, 16, "R6 jump");
    step(1, 5, 12, "R6 backward");
    step(1, 5, 14, "R6 state kept");
    // R7 wrap cases
    step(1, 7, 254, "R7");
    step(1, 7, 255, "R7 254->255");
    step(1, 8, 254, "R7");
    step(1, 8, 1,   "R7 254->1");
    step(1, 9, 255, "R7");
    step(1, 9, 2,   "R7 255->2");
    step(1, 6, 255, "R7");
    step(1, 6, 1,   "R7 255->1");
    step(1, 4, 255, "R7");
    step(1, 4, 3,   "R7 255->3 drop");
    // R8 restart
    step(1, 10, 50, "R8");
    step(1, 10, 0,  "R8 restart");
    step(1, 10, 2,  "R8 0->2");
    step(1, 11, 0,  "R8 first zero");
    step(1, 11, 0,  "R8 repeat zero");
    step(1, 11, 1,  "R8 0->1");
    // R9 interleaved links
    step(1, 1, 100, "R9");
    step(1, 2, 200, "R9");
    step(1, 1, 101, "R9");
    step(1, 2, 202, "R9");
    step(1, 1, 201, "R9 cross drop");
    step(1, 2, 203, "R9");
    // R10 back-to-back same link, with a drop in the middle
    step(1, 20, 30, "R10");
    step(1, 20, 31, "R10");
    step(1, 20, 32, "R10");
    step(1, 20, 34, "R10");
    step(1, 20, 37, "R10 drop");
    step(1, 20, 35, "R10");
    step(1, 20, 35, "R10 dup");
    step(1, 127, 9, "R10 top link");
    step(1, 127, 10, "R10 top link");
    // R11 mixed sweep
    begin
      int lf = 32'h1ACE;
      for (int n = 0; n < 2000; n++) begin
        int l, s;
        lf = (lf >> 1) ^ ((lf & 1) ? 32'hB400 : 0);
        l = lf & 3;
        case ((lf >> 4) & 7)
          0: s = 0;
          1, 2: s = succ(ref_prev[l]);
          3, 4: s = succ(succ(ref_prev[l]));
          5: s = ref_prev[l];
          default: s = (lf >> 8) & 255;
        endcase
        step(((lf >> 12) & 3) != 0, l, s, "R11 sweep");
      end
    end
    step(0, 0, 0, "R2 idle");
    step(0, 0, 0, "R2 idle");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule